// File: doc/BRIEF.md
# Descriptor-chained DMA channel

This block is one DMA channel that moves 32-bit words from a source address to a destination address. Software does not program the transfer into registers directly. It writes the byte address of a control block in memory and then sets the run bit. The channel reads the block over its memory port. The block gives the transfer options, the source, the destination, the byte count, a stride word and a link to the next block. The channel then copies the data one word per beat. After each block it follows the link, and it stops when the link is zero. A block that links back to itself gives an endless ring transfer, for example for an audio buffer.

Each side can step its address by 4 per beat or hold it fixed, which suits a peripheral data register. Either side can be paced by one of the peripheral request lines. The read side can be replaced by zero data, so the channel fills memory with zeros. Software can pause and resume the channel, skip the current block, reset the channel and acknowledge the interrupt. It can also read the live source, destination and remaining-length registers to work out how far the transfer has got.

Each control block is eight words long. In order they are: options (offset 0x00), source (0x04), destination (0x08), byte length (0x0C), stride (0x10) and next link (0x14). The last two words are padding and are never fetched.

Top module: `dmac_chan`

## Requirements
- R1: After reset, status (offset 0x00) reads 0x10: only the paused bit (bit 4) is set. No memory request is issued and the interrupt output is low.
- R2: Software writes a block address to offset 0x04 while the channel is stopped, then writes 1 to status bit 0. The channel then fetches words 0..5 of the block from consecutive addresses. Options, source, destination, length, stride and link read back at 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C.
- R3: Each beat reads one word from the source address and writes it to the destination address. The length register drops by 4 per beat. A block of length 0 moves no data, so only the six fetch reads reach memory.
- R4: Options bit 8 makes the source address step by 4 after each read. Options bit 4 makes the destination address step by 4 after each write. With a bit clear, that address stays fixed. The source and destination registers show the updated addresses.
- R5: Options bit 11 suppresses every source read, and zero is written on each beat.
- R6: Options bit 10 paces reads and options bit 6 paces writes. Options bits 20:16 select one of 32 request lines. A paced beat starts only while the selected line is high. Otherwise status bit 5 (held) reads 1 and the addresses do not move. Status bit 3 shows the level of the selected line.
- R7: When a block completes and its link is non-zero, the channel fetches the linked block. When the link is zero, it clears status bit 0 and stops. A block that links to itself repeats without end.
- R8: Each block completion sets status bit 1. If options bit 0 is set, completion also sets status bit 2 and raises the interrupt output. Writing 1 to bit 1 or bit 2 clears that bit. Blocks with options bit 0 clear never set bit 2.
- R9: Writing 0 to status bit 0 pauses the channel after any memory access in flight has finished. It then issues no new request, and status bit 4 reads 1. Writing 1 again resumes, and the final memory contents are the same as for an uninterrupted run.
- R10: Writing 1 to status bit 30 while a chain is loaded drops the current block without setting bits 1 or 2. The channel then continues at the link register, or stops if the link is zero. The link register (0x1C) is writable while the channel is paused.
- R11: Writing 1 to status bit 31 resets the channel to its reset state once no access is in flight. Status then reads 0x10 again, and the block address and length registers read 0.
- R12: The fetched length is limited to 65532 bytes when LITE=1 and to 1 GiB when LITE=0. Bit 28 of the debug register (0x20) equals LITE.
- R13: A memory request stays asserted with a stable address and direction until the response valid arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| mem_req_o | output | 1 | Memory request, held until the response |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rvalid_i | input | 1 | Memory response (read data valid or write done) |
| mem_rdata_i | input | 32 | Memory read data |
| dreq_i | input | NUM_DREQ | Peripheral request lines |
| irq_o | output | 1 | Interrupt, equal to status bit 2 |

## Verification
The copy path is swept over block lengths of 0 to 6 words and all four combinations of source and destination stepping. The expected memory image, final addresses and read and write counts are computed arithmetically for each case. This separates a wrong stepping side, an off-by-one beat count and a zero-length block that still moves data. Separate runs cover the following:
- the zero-fill option;
- pacing on the wrong and then the right request line, for each side;
- a two-block chain without interrupt;
- a self-linked ring that is acknowledged twice and then stopped by abort;
- a pause partway through a 32-word copy;
- an abort that moves on to a linked block, and an abort that stops the channel;
- the length clamp of both variants, and a soft reset.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int REG_AW = 6;
  localparam int CB_USED = 6;

  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_READ, ST_WRITE, ST_DONE} dmac_state_e;

  localparam logic [REG_AW-1:0] OFS_CS     = 6'h00;
  localparam logic [REG_AW-1:0] OFS_CB     = 6'h04;
  localparam logic [REG_AW-1:0] OFS_INFO   = 6'h08;
  localparam logic [REG_AW-1:0] OFS_SRC    = 6'h0C;
  localparam logic [REG_AW-1:0] OFS_DST    = 6'h10;
  localparam logic [REG_AW-1:0] OFS_LEN    = 6'h14;
  localparam logic [REG_AW-1:0] OFS_STRIDE = 6'h18;
  localparam logic [REG_AW-1:0] OFS_NEXT   = 6'h1C;
  localparam logic [REG_AW-1:0] OFS_DEBUG  = 6'h20;

  localparam int IB_IRQ = 0;
  localparam int IB_DINC = 4;
  localparam int IB_DPACE = 6;
  localparam int IB_SINC = 8;
  localparam int IB_SPACE = 10;
  localparam int IB_SZERO = 11;
  localparam int IB_SEL_LO = 16;

  localparam int CS_ACT = 0;
  localparam int CS_END = 1;
  localparam int CS_INT = 2;
  localparam int CS_LVL = 3;
  localparam int CS_PAUSED = 4;
  localparam int CS_HELD = 5;
  localparam int CS_ABORT = 30;
  localparam int CS_SRST = 31;

  localparam int DBG_LITE = 28;
endpackage

// File: rtl/dmac_pace.sv
module dmac_pace #(
  parameter int NUM_DREQ = 32,
  parameter int SEL_W = 5
) (
  input  logic [NUM_DREQ-1:0] dreq_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                pace_en_i,
  input  logic                want_i,
  output logic                level_o,
  output logic                ok_o,
  output logic                held_o
);
  assign level_o = dreq_i[sel_i];
  assign ok_o    = !pace_en_i || level_o;
  assign held_o  = want_i && pace_en_i && !level_o;
endmodule

// File: rtl/dmac_len_clamp.sv
module dmac_len_clamp #(
  parameter bit LITE = 1'b0
) (
  input  logic [31:0] raw_i,
  output logic [31:0] len_o
);
  logic [31:0] aligned;
  assign aligned = {raw_i[31:2], 2'b00};

  generate
    if (LITE) begin : g_lite
      localparam logic [31:0] MAX_LEN = 32'd65532;
      assign len_o = (aligned > MAX_LEN) ? MAX_LEN : aligned;
    end else begin : g_full
      localparam logic [31:0] MAX_LEN = 32'h4000_0000;
      assign len_o = (aligned > MAX_LEN) ? MAX_LEN : aligned;
    end
  endgenerate
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int NUM_DREQ = 32,
  parameter bit LITE = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [REG_AW-1:0]   reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [31:0]         mem_addr_o,
  output logic [31:0]         mem_wdata_o,
  input  logic                mem_rvalid_i,
  input  logic [31:0]         mem_rdata_i,
  input  logic [NUM_DREQ-1:0] dreq_i,
  output logic                irq_o
);
  localparam int SEL_W = (NUM_DREQ > 1) ? $clog2(NUM_DREQ) : 1;
  localparam logic [31:0] LEN_MAX = LITE ? 32'd65532 : 32'h4000_0000;

  dmac_state_e state_q;
  logic [2:0]  idx_q;
  logic        active_q, end_q, int_q, busy_q, abort_q, srst_q;
  logic [31:0] cb_q, ti_q, src_q, dst_q, len_q, stride_q, nxt_q, data_q;
  logic [31:0] len_ld, src_step, dst_step;
  logic        pace_lvl, pace_ok, pace_held, pace_en, want, paused;

  assign pace_en  = (state_q == ST_WRITE) ? ti_q[IB_DPACE] : ti_q[IB_SPACE];
  assign want     = active_q && !busy_q && !srst_q &&
                    ((state_q == ST_READ && len_q != '0 && !ti_q[IB_SZERO]) ||
                     state_q == ST_WRITE);
  assign paused   = !active_q && !busy_q;
  assign src_step = ti_q[IB_SINC] ? 32'd4 : 32'd0;
  assign dst_step = ti_q[IB_DINC] ? 32'd4 : 32'd0;

  dmac_pace #(.NUM_DREQ(NUM_DREQ), .SEL_W(SEL_W)) u_pace (
    .dreq_i   (dreq_i),
    .sel_i    (ti_q[IB_SEL_LO +: SEL_W]),
    .pace_en_i(pace_en),
    .want_i   (want),
    .level_o  (pace_lvl),
    .ok_o     (pace_ok),
    .held_o   (pace_held)
  );

  dmac_len_clamp #(.LITE(LITE)) u_clamp (
    .raw_i(mem_rdata_i),
    .len_o(len_ld)
  );

  always_comb begin
    case (state_q)
      ST_FETCH: mem_addr_o = cb_q + {27'b0, idx_q, 2'b00};
      ST_READ:  mem_addr_o = src_q;
      default:  mem_addr_o = dst_q;
    endcase
  end
  assign mem_req_o   = busy_q;
  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_wdata_o = data_q;
  assign irq_o       = int_q;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFS_CS: begin
        reg_rdata_o[CS_ACT]    = active_q;
        reg_rdata_o[CS_END]    = end_q;
        reg_rdata_o[CS_INT]    = int_q;
        reg_rdata_o[CS_LVL]    = pace_lvl;
        reg_rdata_o[CS_PAUSED] = paused;
        reg_rdata_o[CS_HELD]   = pace_held;
      end
      OFS_CB:     reg_rdata_o = cb_q;
      OFS_INFO:   reg_rdata_o = ti_q;
      OFS_SRC:    reg_rdata_o = src_q;
      OFS_DST:    reg_rdata_o = dst_q;
      OFS_LEN:    reg_rdata_o = len_q;
      OFS_STRIDE: reg_rdata_o = stride_q;
      OFS_NEXT:   reg_rdata_o = nxt_q;
      OFS_DEBUG:  reg_rdata_o[DBG_LITE] = LITE;
      default:    reg_rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; idx_q <= '0;
      active_q <= 1'b0; end_q <= 1'b0; int_q <= 1'b0;
      busy_q <= 1'b0; abort_q <= 1'b0; srst_q <= 1'b0;
      cb_q <= '0; ti_q <= '0; src_q <= '0; dst_q <= '0;
      len_q <= '0; stride_q <= '0; nxt_q <= '0; data_q <= '0;
    end else if (srst_q && !busy_q) begin
      state_q <= ST_IDLE; idx_q <= '0;
      active_q <= 1'b0; end_q <= 1'b0; int_q <= 1'b0;
      busy_q <= 1'b0; abort_q <= 1'b0; srst_q <= 1'b0;
      cb_q <= '0; ti_q <= '0; src_q <= '0; dst_q <= '0;
      len_q <= '0; stride_q <= '0; nxt_q <= '0; data_q <= '0;
    end else begin
      if (reg_we_i) begin
        case (reg_addr_i)
          OFS_CS: begin
            active_q <= reg_wdata_i[CS_ACT];
            if (reg_wdata_i[CS_END]) end_q <= 1'b0;
            if (reg_wdata_i[CS_INT]) int_q <= 1'b0;
            if (reg_wdata_i[CS_ABORT] && state_q != ST_IDLE) abort_q <= 1'b1;
            if (reg_wdata_i[CS_SRST]) srst_q <= 1'b1;
          end
          OFS_CB:   if (state_q == ST_IDLE && !active_q) cb_q <= reg_wdata_i;
          OFS_NEXT: if (paused) nxt_q <= reg_wdata_i;
          default: ;
        endcase
      end

      if (abort_q && !busy_q) begin
        // drop the current block, continue at the link
        abort_q <= 1'b0;
        if (nxt_q == '0) begin
          active_q <= 1'b0;
          state_q  <= ST_IDLE;
        end else begin
          cb_q    <= nxt_q;
          idx_q   <= '0;
          state_q <= ST_FETCH;
        end
      end else if (busy_q) begin
        if (mem_rvalid_i) begin
          busy_q <= 1'b0;
          case (state_q)
            ST_FETCH: begin
              case (idx_q)
                3'd0: ti_q <= mem_rdata_i;
                3'd1: src_q <= mem_rdata_i;
                3'd2: dst_q <= mem_rdata_i;
                3'd3: len_q <= len_ld;
                3'd4: stride_q <= mem_rdata_i;
                default: nxt_q <= mem_rdata_i;
              endcase
              if (idx_q == 3'(CB_USED - 1)) state_q <= ST_READ;
              else idx_q <= idx_q + 3'd1;
            end
            ST_READ: begin
              data_q  <= mem_rdata_i;
              src_q   <= src_q + src_step;
              state_q <= ST_WRITE;
            end
            ST_WRITE: begin
              dst_q   <= dst_q + dst_step;
              len_q   <= len_q - 32'd4;
              state_q <= ST_READ;
            end
            default: ;
          endcase
        end
      end else if (active_q && !srst_q) begin
        case (state_q)
          ST_IDLE: begin
            idx_q   <= '0;
            state_q <= ST_FETCH;
          end
          ST_FETCH: busy_q <= 1'b1;
          ST_READ: begin
            if (len_q == '0) state_q <= ST_DONE;
            else if (ti_q[IB_SZERO]) begin
              data_q  <= '0;
              state_q <= ST_WRITE;
            end else if (pace_ok) busy_q <= 1'b1;
          end
          ST_WRITE: if (pace_ok) busy_q <= 1'b1;
          ST_DONE: begin
            end_q <= 1'b1;
            if (ti_q[IB_IRQ]) int_q <= 1'b1;
            if (nxt_q == '0) begin
              active_q <= 1'b0;
              state_q  <= ST_IDLE;
            end else begin
              cb_q    <= nxt_q;
              idx_q   <= '0;
              state_q <= ST_FETCH;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R13
  bus_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  // R9
  pause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q && !mem_req_o |=> !mem_req_o);

  // R6
  src_pace_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) && state_q == ST_READ && ti_q[IB_SPACE] |-> $past(pace_lvl));

  // R6
  dst_pace_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) && mem_we_o && ti_q[IB_DPACE] |-> $past(pace_lvl));

  // R8
  irq_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> end_q);

  // R12
  len_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_q <= LEN_MAX);
endmodule

// File: tb/dmac_chan_bench.sv
module dmac_chan_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_CS = 6'h00, A_CB = 6'h04, A_INFO = 6'h08, A_SRC = 6'h0C,
                         A_DST = 6'h10, A_LEN = 6'h14, A_NEXT = 6'h1C, A_DBG = 6'h20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        we = 1'b0, l_we = 1'b0;
  logic [5:0]  addr = '0, l_addr = '0;
  logic [31:0] wdata = '0, l_wdata = '0, rdata, l_rdata;
  logic        m_req, m_we, m_rv, irq;
  logic [31:0] m_addr, m_wdata, m_rd;
  logic        l_req, l_mwe, l_rv, l_irq;
  logic [31:0] l_maddr, l_mwdata, l_rd;
  logic [31:0] dreq = '0;
  logic [31:0] l_dreq = '0;

  logic [31:0] mem [0:1023];
  int rd_cnt = 0, wr_cnt = 0, viol = 0;
  logic        p_req = 1'b0, p_rv = 1'b0, p_we = 1'b0;
  logic [31:0] p_addr = '0;
  int n_chk = 0, n_fail = 0;

  dmac_chan u_dmac_chan (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .mem_req_o(m_req), .mem_we_o(m_we), .mem_addr_o(m_addr),
    .mem_wdata_o(m_wdata), .mem_rvalid_i(m_rv), .mem_rdata_i(m_rd), .dreq_i(dreq), .irq_o(irq)
  );

  dmac_chan #(.LITE(1'b1)) u_lite (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(l_we), .reg_addr_i(l_addr), .reg_wdata_i(l_wdata),
    .reg_rdata_o(l_rdata), .mem_req_o(l_req), .mem_we_o(l_mwe), .mem_addr_o(l_maddr),
    .mem_wdata_o(l_mwdata), .mem_rvalid_i(l_rv), .mem_rdata_i(l_rd), .dreq_i(l_dreq), .irq_o(l_irq)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rv <= 1'b0; m_rd <= '0;
    end else if (m_req && !m_rv) begin
      m_rv <= 1'b1;
      if (m_we) begin mem[m_addr[11:2]] <= m_wdata; wr_cnt <= wr_cnt + 1; end
      else begin m_rd <= mem[m_addr[11:2]]; rd_cnt <= rd_cnt + 1; end
    end else m_rv <= 1'b0;
    if (rst_n && p_req && !p_rv && (!m_req || m_addr != p_addr || m_we != p_we)) viol <= viol + 1;
    p_req <= m_req; p_rv <= m_rv; p_addr <= m_addr; p_we <= m_we;
  end

  always @(posedge clk) begin
    if (!rst_n) begin l_rv <= 1'b0; l_rd <= '0; end
    else if (l_req && !l_rv) begin l_rv <= 1'b1; l_rd <= mem[l_maddr[11:2]]; end
    else l_rv <= 1'b0;
  end

  function automatic logic [9:0] wi(input int a);
    return a[11:2];
  endfunction

  function automatic logic [31:0] pat(input int k);
    return 32'h5A00_0000 + 32'(k) * 32'h0001_0003;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit lite, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    if (lite) begin l_we = 1'b1; l_addr = a; l_wdata = d; end
    else begin we = 1'b1; addr = a; wdata = d; end
    @(negedge clk);
    we = 1'b0; l_we = 1'b0;
  endtask

  task automatic rd(input bit lite, input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; l_addr = a;
    #1;
    d = lite ? l_rdata : rdata;
  endtask

  task automatic wait_stop(input int max);
    logic [31:0] v;
    for (int i = 0; i < max; i++) begin
      rd(1'b0, A_CS, v);
      if (!v[0]) break;
    end
  endtask

  task automatic put_cb(input int base, input logic [31:0] ti, input logic [31:0] s,
                        input logic [31:0] d, input logic [31:0] len, input logic [31:0] nx);
    mem[wi(base)] = ti; mem[wi(base + 4)] = s; mem[wi(base + 8)] = d;
    mem[wi(base + 12)] = len; mem[wi(base + 16)] = 32'h0; mem[wi(base + 20)] = nx;
    mem[wi(base + 24)] = 32'hFFFF_FFFF; mem[wi(base + 28)] = 32'hFFFF_FFFF;
  endtask

  task automatic start(input logic [31:0] cb);
    wr(1'b0, A_CB, cb);
    wr(1'b0, A_CS, 32'h1);
  endtask

  task automatic fill(input int base, input int words, input logic [31:0] seed);
    for (int k = 0; k < words; k++) mem[wi(base + 4*k)] = seed + 32'(k);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, s1, d1, ti, e;
    int r0, w0, errs;
    for (int k = 0; k < 1024; k++) mem[k] = '0;
    for (int k = 0; k < 40; k++) mem[wi(32'h400 + 4*k)] = pat(k);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(1'b0, A_CS, v); chk("R1 status", v, 32'h10);
    chk("R1 req", {31'b0, m_req}, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 R3 R4 R8: length and stepping sweep
    for (int n = 0; n <= 6; n++) begin
      for (int m = 0; m < 4; m++) begin
        bit si, di;
        si = m[0]; di = m[1];
        fill(32'h800, 8, 32'hDEAD_0000);
        ti = 32'h1 | (32'(si) << 8) | (32'(di) << 4);
        put_cb(32'h100, ti, 32'h400, 32'h800, 32'(n*4), 32'h0);
        r0 = rd_cnt; w0 = wr_cnt;
        start(32'h100);
        wait_stop(500);
        errs = 0;
        for (int k = 0; k < 8; k++) begin
          if (di) e = (k < n) ? pat(si ? k : 0) : 32'hDEAD_0000 + 32'(k);
          else e = (k == 0 && n > 0) ? pat(si ? n - 1 : 0) : 32'hDEAD_0000 + 32'(k);
          if (mem[wi(32'h800 + 4*k)] !== e) errs++;
        end
        chk("R3 data mismatches", 32'(errs), 32'h0);
        rd(1'b0, A_SRC, v); chk("R4 src end", v, 32'h400 + (si ? 32'(4*n) : 32'h0));
        rd(1'b0, A_DST, v); chk("R4 dst end", v, 32'h800 + (di ? 32'(4*n) : 32'h0));
        rd(1'b0, A_LEN, v); chk("R3 len end", v, 32'h0);
        chk("R3 reads", 32'(rd_cnt - r0), 32'(6 + n));
        chk("R3 writes", 32'(wr_cnt - w0), 32'(n));
        rd(1'b0, A_INFO, v); chk("R2 info readback", v, ti);
        rd(1'b0, A_CS, v); chk("R8 status after block", {26'b0, v[5:0]}, 32'h16);
        chk("R8 irq", {31'b0, irq}, 32'h1);
        wr(1'b0, A_CS, 32'h6);
        rd(1'b0, A_CS, v); chk("R8 ack", {26'b0, v[5:0]}, 32'h10);
      end
    end

    // R5 zero fill
    fill(32'hB00, 4, 32'h1234_0000);
    put_cb(32'h100, 32'h0000_0910, 32'h400, 32'hB00, 32'd12, 32'h0);
    r0 = rd_cnt;
    start(32'h100); wait_stop(500);
    chk("R5 word0", mem[wi(32'hB00)], 32'h0);
    chk("R5 word2", mem[wi(32'hB08)], 32'h0);
    chk("R5 word3 untouched", mem[wi(32'hB0C)], 32'h1234_0003);
    chk("R5 no source reads", 32'(rd_cnt - r0), 32'd6);
    wr(1'b0, A_CS, 32'h6);

    // R6 source pacing on line 5
    fill(32'h800, 8, 32'hDEAD_0000);
    put_cb(32'h100, 32'h0005_0510, 32'h400, 32'h800, 32'd12, 32'h0);
    start(32'h100);
    repeat (40) @(negedge clk);
    rd(1'b0, A_CS, v); chk("R6 held", {31'b0, v[5]}, 32'h1);
    chk("R6 level low", {31'b0, v[3]}, 32'h0);
    rd(1'b0, A_SRC, v); chk("R6 src not moved", v, 32'h400);
    dreq[4] = 1'b1;
    repeat (20) @(negedge clk);
    rd(1'b0, A_SRC, v); chk("R6 wrong line ignored", v, 32'h400);
    dreq[5] = 1'b1;
    wait_stop(500);
    chk("R6 paced data", mem[wi(32'h808)], pat(2));
    dreq = '0;
    wr(1'b0, A_CS, 32'h6);

    // R6 destination pacing on line 7
    put_cb(32'h100, 32'h0007_0150, 32'h400, 32'h800, 32'd8, 32'h0);
    start(32'h100);
    repeat (40) @(negedge clk);
    rd(1'b0, A_SRC, v); chk("R6 read done before held write", v, 32'h404);
    rd(1'b0, A_DST, v); chk("R6 dst held", v, 32'h800);
    dreq[7] = 1'b1;
    wait_stop(500);
    rd(1'b0, A_DST, v); chk("R6 dst after release", v, 32'h808);
    dreq = '0;
    wr(1'b0, A_CS, 32'h6);

    // R7 two-block chain, no interrupt requested
    fill(32'h800, 4, 32'h0); fill(32'h900, 4, 32'h0);
    put_cb(32'h100, 32'h0000_0110, 32'h400, 32'h800, 32'd8, 32'h140);
    put_cb(32'h140, 32'h0000_0110, 32'h420, 32'h900, 32'd8, 32'h0);
    start(32'h100); wait_stop(500);
    chk("R7 first block", mem[wi(32'h804)], pat(1));
    chk("R7 second block", mem[wi(32'h904)], pat(9));
    rd(1'b0, A_CS, v); chk("R8 end without int", {29'b0, v[2:0]}, 32'h2);
    chk("R8 irq low", {31'b0, irq}, 32'h0);
    wr(1'b0, A_CS, 32'h2);

    // R7 ring, R9 pause, R10 abort to stop
    fill(32'hA00, 4, 32'h0);
    put_cb(32'h180, 32'h0000_0111, 32'h400, 32'hA00, 32'd8, 32'h180);
    start(32'h180);
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 500 && !irq; i++) @(negedge clk);
      chk("R7 ring completion", {31'b0, irq}, 32'h1);
      wr(1'b0, A_CS, 32'h5);
    end
    chk("R7 ring data", mem[wi(32'hA04)], pat(1));
    wr(1'b0, A_CS, 32'h0);
    repeat (10) @(negedge clk);
    rd(1'b0, A_CS, v); chk("R9 paused flag", {31'b0, v[4]}, 32'h1);
    wr(1'b0, A_NEXT, 32'h0);
    rd(1'b0, A_NEXT, v); chk("R10 link writable", v, 32'h0);
    wr(1'b0, A_CS, 32'h4000_0001);
    wait_stop(100);
    rd(1'b0, A_CS, v); chk("R10 ring stopped", {31'b0, v[0]}, 32'h0);
    wr(1'b0, A_CS, 32'h6);

    // R9 pause in the middle of a 32-word copy
    fill(32'hC00, 32, 32'h0);
    put_cb(32'h100, 32'h0000_0110, 32'h400, 32'hC00, 32'd128, 32'h0);
    start(32'h100);
    repeat (30) @(negedge clk);
    wr(1'b0, A_CS, 32'h0);
    repeat (5) @(negedge clk);
    rd(1'b0, A_SRC, s1); rd(1'b0, A_DST, d1);
    w0 = wr_cnt;
    repeat (40) @(negedge clk);
    rd(1'b0, A_SRC, v); chk("R9 src frozen", v, s1);
    rd(1'b0, A_DST, v); chk("R9 dst frozen", v, d1);
    chk("R9 no writes while paused", 32'(wr_cnt - w0), 32'h0);
    chk("R9 no request", {31'b0, m_req}, 32'h0);
    chk("R9 paused mid block", {31'b0, (d1 > 32'hC00 && d1 < 32'hC80)}, 32'h1);
    wr(1'b0, A_CS, 32'h1);
    wait_stop(1000);
    errs = 0;
    for (int k = 0; k < 32; k++) if (mem[wi(32'hC00 + 4*k)] !== pat(k)) errs++;
    chk("R9 resumed data", 32'(errs), 32'h0);
    wr(1'b0, A_CS, 32'h6);

    // R10 abort moves on to the linked block
    fill(32'hD00, 4, 32'h7777_0000); fill(32'hE00, 2, 32'h0);
    put_cb(32'h100, 32'h0009_0511, 32'h400, 32'hD00, 32'd16, 32'h140);
    put_cb(32'h140, 32'h0000_0111, 32'h400, 32'hE00, 32'd4, 32'h0);
    start(32'h100);
    repeat (40) @(negedge clk);
    wr(1'b0, A_CS, 32'h4000_0001);
    wait_stop(500);
    chk("R10 skipped block untouched", mem[wi(32'hD00)], 32'h7777_0000);
    chk("R10 linked block ran", mem[wi(32'hE00)], pat(0));
    chk("R10 linked block ends", {31'b0, irq}, 32'h1);
    wr(1'b0, A_CS, 32'h6);

    // R10 abort with zero link stops without flags
    put_cb(32'h100, 32'h0009_0511, 32'h400, 32'hD00, 32'd16, 32'h0);
    start(32'h100);
    repeat (40) @(negedge clk);
    wr(1'b0, A_CS, 32'h4000_0001);
    wait_stop(100);
    rd(1'b0, A_CS, v); chk("R10 stop no end no int", {29'b0, v[2:0]}, 32'h0);

    // R12 full-size clamp, then R11 soft reset while held
    put_cb(32'h100, 32'h0003_0510, 32'h400, 32'hD00, 32'hFFFF_FFF0, 32'h0);
    start(32'h100);
    repeat (30) @(negedge clk);
    rd(1'b0, A_LEN, v); chk("R12 full clamp", v, 32'h4000_0000);
    rd(1'b0, A_DBG, v); chk("R12 full debug flag", {31'b0, v[28]}, 32'h0);
    wr(1'b0, A_CS, 32'h8000_0000);
    repeat (5) @(negedge clk);
    rd(1'b0, A_CS, v); chk("R11 status after soft reset", v, 32'h10);
    rd(1'b0, A_CB, v); chk("R11 block address cleared", v, 32'h0);
    rd(1'b0, A_LEN, v); chk("R11 length cleared", v, 32'h0);
    chk("R11 no request", {31'b0, m_req}, 32'h0);

    // R12 reduced variant clamp
    put_cb(32'h1C0, 32'h0000_0510, 32'h400, 32'hD00, 32'h0002_0000, 32'h0);
    wr(1'b1, A_CB, 32'h1C0);
    wr(1'b1, A_CS, 32'h1);
    repeat (30) @(negedge clk);
    rd(1'b1, A_LEN, v); chk("R12 lite clamp", v, 32'd65532);
    rd(1'b1, A_DBG, v); chk("R12 lite debug flag", {31'b0, v[28]}, 32'h1);

    // R13 request held until response
    chk("R13 protocol violations", 32'(viol), 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule